// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic core of a small accumulator-based microcontroller. In one cycle, and without a clock, it computes the result of an 8-bit compare, increment or decrement, a 16-bit add, subtract, compare, increment or decrement, one of four one-position rotates of the accumulator, or a carry-flag control operation. Alongside the result it drives a writeback enable, a flag for a 16-bit result, the candidate values of the zero (Z), auxiliary carry (AC) and carry (CY) flags, and one update enable per flag.

A clocked flag register holds Z, AC and CY. Each flag takes its candidate value at the rising edge only when its own enable is high. A synchronous reset clears all three. The rotate-through-carry operations read the registered CY. The surrounding sequencer supplies the operation code, the accumulator, an 8-bit operand, a 16-bit register pair (also used as the accumulator pair) and a 16-bit immediate. It takes the result when the writeback enable is high.

Top module: `acc_alu`

## Requirements
- R1: Code 1 (8-bit compare) drives res_o = {8'h00, acc_i − opnd_i mod 256}, wb_o = 0 and wide_o = 0. It enables all three flags, with Z = (difference is zero), AC = (acc_i[3:0] < opnd_i[3:0]) and CY = (acc_i < opnd_i, unsigned).
- R2: Codes 2 and 3 (8-bit increment and decrement) drive res_o = {8'h00, opnd_i ± 1 mod 256}, wb_o = 1 and wide_o = 0. They enable Z and AC only. AC is set when opnd_i[3:0] was 4'hF for increment, or 4'h0 for decrement. CY keeps its value.
- R3: Code 4 (16-bit add) drives res_o = pair_i + imm_i mod 65536, wb_o = 1 and wide_o = 1. It enables all flags, with CY = carry out of bit 15, AC = carry out of bit 3, and Z = (sum is zero).
- R4: Codes 5 and 6 (16-bit subtract and compare) drive res_o = pair_i − imm_i mod 65536 with wide_o = 1. wb_o is 1 for code 5 and 0 for code 6. Both enable all flags, with CY = (pair_i < imm_i), AC = (pair_i[3:0] < imm_i[3:0]) and Z = (difference is zero).
- R5: Codes 7 and 8 (pair increment and decrement) drive res_o = pair_i ± 1 mod 65536, wb_o = 1 and wide_o = 1. They enable no flag, so Z, AC and CY stay unchanged.
- R6: Code 9 (rotate right) gives {acc_i[0], acc_i[7:1]} with CY = acc_i[0]. Code 10 (rotate left) gives {acc_i[6:0], acc_i[7]} with CY = acc_i[7]. Both drive wb_o = 1 and wide_o = 0.
- R7: Code 11 (rotate right through carry) gives {old CY, acc_i[7:1]} with CY = acc_i[0]. Code 12 (rotate left through carry) gives {acc_i[6:0], old CY} with CY = acc_i[7]. Both drive wb_o = 1 and wide_o = 0.
- R8: The four rotates enable CY only, and Z and AC keep their values.
- R9: Codes 13, 14 and 15 set CY to 1, clear CY to 0 and invert CY respectively. They enable CY only, drive res_o = 0 and wb_o = 0, and leave Z and AC unchanged.
- R10: At each rising edge out of reset, a flag output takes its candidate output value when its enable is 1 and holds otherwise. The registered flags are z_o, ac_o and cy_o.
- R11: A high rst at a rising edge clears z_o, ac_o and cy_o.
- R12: Code 0 (no operation) drives res_o = 0, wb_o = 0, wide_o = 0 and no flag enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code (0 to 15) |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | 8-bit operand (subtrahend or increment target) |
| pair_i | input | 16 | Register pair or accumulator pair |
| imm_i | input | 16 | 16-bit immediate |
| res_o | output | 16 | Result; 8-bit results in the low byte |
| wide_o | output | 1 | Result is 16 bits wide |
| wb_o | output | 1 | Result is to be written back |
| z_nxt_o | output | 1 | Candidate zero flag |
| ac_nxt_o | output | 1 | Candidate auxiliary carry flag |
| cy_nxt_o | output | 1 | Candidate carry flag |
| z_en_o | output | 1 | Zero flag update enable |
| ac_en_o | output | 1 | Auxiliary carry update enable |
| cy_en_o | output | 1 | Carry update enable |
| z_o | output | 1 | Registered zero flag |
| ac_o | output | 1 | Registered auxiliary carry flag |
| cy_o | output | 1 | Registered carry flag |

## Verification
The result, the writeback and width outputs, and the flag candidates and enables are combinational, so they are due in the same cycle the operation is presented. The registered flags are due just after the following rising edge. The bench drives one operation per falling edge and queues the expected item. The monitor checks the combinational outputs of that item 1 ns after the same falling edge. At the next falling edge it checks the registered flags of the previous item, one rising edge later. The operations that read CY (rotates through carry, carry invert) therefore see exactly the flags left by the preceding operation.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_CMP  = 4'd1,
        OP_INC  = 4'd2,
        OP_DEC  = 4'd3,
        OP_ADDW = 4'd4,
        OP_SUBW = 4'd5,
        OP_CMPW = 4'd6,
        OP_INCW = 4'd7,
        OP_DECW = 4'd8,
        OP_ROR  = 4'd9,
        OP_ROL  = 4'd10,
        OP_RORC = 4'd11,
        OP_ROLC = 4'd12,
        OP_SETC = 4'd13,
        OP_CLRC = 4'd14,
        OP_NOTC = 4'd15
    } alu_op_e;

    // flag vector layout, most significant first
    typedef struct packed {
        logic z;
        logic ac;
        logic cy;
    } flags_t;

    localparam int NFLAG = 3;

endpackage

// File: rtl/acc_alu_addsub.sv
// Adder/subtractor with carry (or borrow) out and half carry at bit HC.
module acc_alu_addsub #(
    parameter int W  = 8,
    parameter int HC = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         hc_o
);
    logic [W-1:0] bx;
    logic [W:0]   full;

    always_comb begin
        bx     = sub_i ? ~b_i : b_i;
        full   = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, sub_i};
        sum_o  = full[W-1:0];
        // carry out inverted on subtract gives the borrow
        cout_o = full[W] ^ sub_i;
        // carry into bit HC recovered from the sum bit
        hc_o   = sum_o[HC] ^ a_i[HC] ^ bx[HC] ^ sub_i;
    end
endmodule

// File: rtl/acc_alu_rot.sv
// One-position rotate, plain or through carry.
module acc_alu_rot #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         cy_i,
    input  logic         left_i,
    input  logic         thru_i,
    output logic [W-1:0] res_o,
    output logic         cy_o
);
    logic fill;

    always_comb begin
        if (left_i) begin
            fill  = thru_i ? cy_i : a_i[W-1];
            res_o = {a_i[W-2:0], fill};
            cy_o  = a_i[W-1];
        end else begin
            fill  = thru_i ? cy_i : a_i[0];
            res_o = {fill, a_i[W-1:1]};
            cy_o  = a_i[0];
        end
    end
endmodule

// File: rtl/acc_alu_flags.sv
// Per-flag enabled register with synchronous clear.
module acc_alu_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] nxt_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= 1'b0;
            else if (en_i[g])
                bit_q <= nxt_i[g];
        end
        assign q_o[g] = bit_q;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    op_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] opnd_i,
    input  logic [2*DW-1:0] pair_i,
    input  logic [2*DW-1:0] imm_i,
    output logic [2*DW-1:0] res_o,
    output logic          wide_o,
    output logic          wb_o,
    output logic          z_nxt_o,
    output logic          ac_nxt_o,
    output logic          cy_nxt_o,
    output logic          z_en_o,
    output logic          ac_en_o,
    output logic          cy_en_o,
    output logic          z_o,
    output logic          ac_o,
    output logic          cy_o
);
    localparam int WW = 2 * DW;
    localparam int HC = 4;

    alu_op_e op;
    flags_t  cur, nxt, en;

    logic [DW-1:0] a8, b8, s8, r8;
    logic          sub8, c8, h8, rcy;
    logic [WW-1:0] b16, s16;
    logic          sub16, c16, h16;

    assign op = alu_op_e'(op_i);

    // operand steering for the narrow unit
    always_comb begin
        a8   = (op == OP_CMP) ? acc_i  : opnd_i;
        b8   = (op == OP_CMP) ? opnd_i : {{(DW-1){1'b0}}, 1'b1};
        sub8 = (op != OP_INC);
    end

    // operand steering for the wide unit
    always_comb begin
        b16   = (op == OP_INCW || op == OP_DECW) ? {{(WW-1){1'b0}}, 1'b1} : imm_i;
        sub16 = (op == OP_SUBW || op == OP_CMPW || op == OP_DECW);
    end

    acc_alu_addsub #(.W(DW), .HC(HC)) u_add8 (
        .a_i(a8), .b_i(b8), .sub_i(sub8),
        .sum_o(s8), .cout_o(c8), .hc_o(h8)
    );

    acc_alu_addsub #(.W(WW), .HC(HC)) u_add16 (
        .a_i(pair_i), .b_i(b16), .sub_i(sub16),
        .sum_o(s16), .cout_o(c16), .hc_o(h16)
    );

    acc_alu_rot #(.W(DW)) u_rot (
        .a_i(acc_i), .cy_i(cur.cy),
        .left_i(op == OP_ROL || op == OP_ROLC),
        .thru_i(op == OP_RORC || op == OP_ROLC),
        .res_o(r8), .cy_o(rcy)
    );

    // result, writeback and flag selection
    always_comb begin
        res_o  = '0;
        wide_o = 1'b0;
        wb_o   = 1'b0;
        nxt    = cur;
        en     = '0;
        unique case (op)
            OP_NOP: begin
            end
            OP_CMP: begin
                res_o = {{DW{1'b0}}, s8};
                nxt.z = (s8 == '0); nxt.ac = h8; nxt.cy = c8;
                en.z = 1'b1; en.ac = 1'b1; en.cy = 1'b1;
            end
            OP_INC, OP_DEC: begin
                res_o = {{DW{1'b0}}, s8};
                wb_o  = 1'b1;
                nxt.z = (s8 == '0); nxt.ac = h8;
                en.z = 1'b1; en.ac = 1'b1;
            end
            OP_ADDW, OP_SUBW, OP_CMPW: begin
                res_o  = s16;
                wide_o = 1'b1;
                wb_o   = (op != OP_CMPW);
                nxt.z = (s16 == '0); nxt.ac = h16; nxt.cy = c16;
                en.z = 1'b1; en.ac = 1'b1; en.cy = 1'b1;
            end
            OP_INCW, OP_DECW: begin
                res_o  = s16;
                wide_o = 1'b1;
                wb_o   = 1'b1;
            end
            OP_ROR, OP_ROL, OP_RORC, OP_ROLC: begin
                res_o  = {{DW{1'b0}}, r8};
                wb_o   = 1'b1;
                nxt.cy = rcy;
                en.cy  = 1'b1;
            end
            OP_SETC: begin
                nxt.cy = 1'b1; en.cy = 1'b1;
            end
            OP_CLRC: begin
                nxt.cy = 1'b0; en.cy = 1'b1;
            end
            OP_NOTC: begin
                nxt.cy = ~cur.cy; en.cy = 1'b1;
            end
        endcase
    end

    acc_alu_flags #(.N(NFLAG)) u_flags (
        .clk(clk), .rst(rst),
        .nxt_i(nxt), .en_i(en), .q_o(cur)
    );

    assign z_nxt_o  = nxt.z;
    assign ac_nxt_o = nxt.ac;
    assign cy_nxt_o = nxt.cy;
    assign z_en_o   = en.z;
    assign ac_en_o  = en.ac;
    assign cy_en_o  = en.cy;
    assign z_o      = cur.z;
    assign ac_o     = cur.ac;
    assign cy_o     = cur.cy;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [3:0] op_i,
    input logic       wide_o,
    input logic       wb_o,
    input logic       z_nxt_o,
    input logic       cy_nxt_o,
    input logic       z_en_o,
    input logic       ac_en_o,
    input logic       cy_en_o,
    input logic       z_o,
    input logic       ac_o,
    input logic       cy_o
);
    // R11
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!z_o && !ac_o && !cy_o));

    // R1
    cmp_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CMP) |-> (!wb_o && z_en_o && ac_en_o && cy_en_o));

    // R4
    cmpw_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CMPW) |-> (!wb_o && wide_o));

    // R2
    incdec_keep_cy_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_INC || op_i == OP_DEC) |=> $stable(cy_o));

    // R5
    pair_step_keep_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_INCW || op_i == OP_DECW) |=> $stable({z_o, ac_o, cy_o}));

    // R8
    rotate_keep_z_ac_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ROR || op_i == OP_ROL || op_i == OP_RORC || op_i == OP_ROLC)
        |=> $stable({z_o, ac_o}));

    // R9
    setc_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SETC) |=> (cy_o && $stable({z_o, ac_o})));

    // R9
    clrc_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CLRC) |=> (!cy_o && $stable({z_o, ac_o})));

    // R9
    notc_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_NOTC) |=> (cy_o != $past(cy_o)));

    // R10
    z_load_chk: assert property (@(posedge clk) disable iff (rst)
        z_en_o |=> (z_o == $past(z_nxt_o)));

    // R10
    z_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !z_en_o |=> $stable(z_o));

    // R10
    cy_load_chk: assert property (@(posedge clk) disable iff (rst)
        cy_en_o |=> (cy_o == $past(cy_nxt_o)));

    // R10
    cy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cy_en_o |=> $stable(cy_o));

    // R12
    nop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_NOP) |-> (!wb_o && !wide_o && !z_en_o && !ac_en_o && !cy_en_o));
endmodule

bind acc_alu acc_alu_chk u_chk (
    .clk(clk), .rst(rst), .op_i(op_i), .wide_o(wide_o), .wb_o(wb_o),
    .z_nxt_o(z_nxt_o), .cy_nxt_o(cy_nxt_o),
    .z_en_o(z_en_o), .ac_en_o(ac_en_o), .cy_en_o(cy_en_o),
    .z_o(z_o), .ac_o(ac_o), .cy_o(cy_o)
);

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
    localparam logic [3:0] K_NOP = 4'd0,  K_CMP = 4'd1,  K_INC = 4'd2,  K_DEC = 4'd3;
    localparam logic [3:0] K_ADDW = 4'd4, K_SUBW = 4'd5, K_CMPW = 4'd6, K_INCW = 4'd7;
    localparam logic [3:0] K_DECW = 4'd8, K_ROR = 4'd9,  K_ROL = 4'd10, K_RORC = 4'd11;
    localparam logic [3:0] K_ROLC = 4'd12, K_SETC = 4'd13, K_CLRC = 4'd14, K_NOTC = 4'd15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = 4'd0;
    logic [7:0]  acc_i = 8'd0, opnd_i = 8'd0;
    logic [15:0] pair_i = 16'd0, imm_i = 16'd0;
    logic [15:0] res_o;
    logic        wide_o, wb_o, z_nxt_o, ac_nxt_o, cy_nxt_o;
    logic        z_en_o, ac_en_o, cy_en_o, z_o, ac_o, cy_o;

    always #2.5 clk = ~clk;

    acc_alu u_acc_alu (
        .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
        .pair_i(pair_i), .imm_i(imm_i), .res_o(res_o), .wide_o(wide_o), .wb_o(wb_o),
        .z_nxt_o(z_nxt_o), .ac_nxt_o(ac_nxt_o), .cy_nxt_o(cy_nxt_o),
        .z_en_o(z_en_o), .ac_en_o(ac_en_o), .cy_en_o(cy_en_o),
        .z_o(z_o), .ac_o(ac_o), .cy_o(cy_o)
    );

    typedef struct {
        logic [3:0]  op;
        logic [15:0] res;
        logic        wide;
        logic        wb;
        logic [2:0]  en;     // {z, ac, cy}
        logic [2:0]  nxt;
        logic [2:0]  after;
    } item_t;

    item_t q[$];
    logic [2:0] m_fl = 3'b000;   // model flags {z, ac, cy}
    int total = 0;
    int bad = 0;

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            K_CMP:                         return "R1";
            K_INC, K_DEC:                  return "R2";
            K_ADDW:                        return "R3";
            K_SUBW, K_CMPW:                return "R4";
            K_INCW, K_DECW:                return "R5";
            K_ROR, K_ROL:                  return "R6";
            K_RORC, K_ROLC:                return "R7";
            K_SETC, K_CLRC, K_NOTC:        return "R9";
            default:                       return "R12";
        endcase
    endfunction

    // driver: computes the expected item from the requirements and queues it
    task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [15:0] p, input logic [15:0] w);
        item_t it;
        logic [16:0] t;
        it.op = op; it.res = 16'h0; it.wide = 1'b0; it.wb = 1'b0;
        it.en = 3'b000; it.nxt = 3'b000;
        case (op)
            K_CMP: begin
                it.res = {8'h00, a - b};
                it.en  = 3'b111;
                it.nxt = {(a == b), (a[3:0] < b[3:0]), (a < b)};
            end
            K_INC: begin
                it.res = {8'h00, b + 8'd1}; it.wb = 1'b1; it.en = 3'b110;
                it.nxt = {(b == 8'hFF), (b[3:0] == 4'hF), 1'b0};
            end
            K_DEC: begin
                it.res = {8'h00, b - 8'd1}; it.wb = 1'b1; it.en = 3'b110;
                it.nxt = {(b == 8'h01), (b[3:0] == 4'h0), 1'b0};
            end
            K_ADDW: begin
                t = {1'b0, p} + {1'b0, w};
                it.res = t[15:0]; it.wide = 1'b1; it.wb = 1'b1; it.en = 3'b111;
                it.nxt = {(t[15:0] == 16'h0), (({1'b0, p[3:0]} + {1'b0, w[3:0]}) > 5'd15), t[16]};
            end
            K_SUBW, K_CMPW: begin
                it.res = p - w; it.wide = 1'b1; it.wb = (op == K_SUBW); it.en = 3'b111;
                it.nxt = {(p == w), (p[3:0] < w[3:0]), (p < w)};
            end
            K_INCW: begin it.res = p + 16'd1; it.wide = 1'b1; it.wb = 1'b1; end
            K_DECW: begin it.res = p - 16'd1; it.wide = 1'b1; it.wb = 1'b1; end
            K_ROR:  begin it.res = {8'h00, a[0], a[7:1]};  it.wb = 1'b1; it.en = 3'b001; it.nxt = {2'b00, a[0]}; end
            K_ROL:  begin it.res = {8'h00, a[6:0], a[7]};  it.wb = 1'b1; it.en = 3'b001; it.nxt = {2'b00, a[7]}; end
            K_RORC: begin it.res = {8'h00, m_fl[0], a[7:1]}; it.wb = 1'b1; it.en = 3'b001; it.nxt = {2'b00, a[0]}; end
            K_ROLC: begin it.res = {8'h00, a[6:0], m_fl[0]}; it.wb = 1'b1; it.en = 3'b001; it.nxt = {2'b00, a[7]}; end
            K_SETC: begin it.en = 3'b001; it.nxt = 3'b001; end
            K_CLRC: begin it.en = 3'b001; it.nxt = 3'b000; end
            K_NOTC: begin it.en = 3'b001; it.nxt = {2'b00, ~m_fl[0]}; end
            default: begin end
        endcase
        for (int i = 0; i < 3; i++)
            it.after[i] = it.en[i] ? it.nxt[i] : m_fl[i];
        m_fl = it.after;
        @(negedge clk);
        op_i = op; acc_i = a; opnd_i = b; pair_i = p; imm_i = w;
        q.push_back(it);
    endtask

    // monitor: combinational outputs in the drive cycle, flags one edge later
    item_t prev;
    logic  have_prev = 1'b0;
    initial begin
        forever begin
            item_t cur;
            string tg;
            @(negedge clk);
            #1;
            if (have_prev) begin
                tg = (prev.op >= K_ROR && prev.op <= K_ROLC) ? "R8" : "R10";
                chk({z_o, ac_o, cy_o} == prev.after, tg, "flags after edge",
                    {13'h0, z_o, ac_o, cy_o}, {13'h0, prev.after});
                have_prev = 1'b0;
            end
            if (q.size() > 0) begin
                cur = q.pop_front();
                tg  = tag_of(cur.op);
                chk(res_o == cur.res, tg, "result", res_o, cur.res);
                chk(wb_o == cur.wb && wide_o == cur.wide, tg, "wb/wide",
                    {14'h0, wb_o, wide_o}, {14'h0, cur.wb, cur.wide});
                chk({z_en_o, ac_en_o, cy_en_o} == cur.en, tg, "flag enables",
                    {13'h0, z_en_o, ac_en_o, cy_en_o}, {13'h0, cur.en});
                chk((({z_nxt_o, ac_nxt_o, cy_nxt_o} ^ cur.nxt) & cur.en) == 3'b000, tg,
                    "flag candidates", {13'h0, z_nxt_o, ac_nxt_o, cy_nxt_o}, {13'h0, cur.nxt});
                prev = cur;
                have_prev = 1'b1;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; op_i = K_NOP;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_fl = 3'b000;
        #1;
        // R11: flags cleared by the synchronous reset
        chk({z_o, ac_o, cy_o} == 3'b000, "R11", "flags after reset",
            {13'h0, z_o, ac_o, cy_o}, 16'h0);
    endtask

    initial begin
        #(5.0 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        drive(K_NOP,  8'h00, 8'h00, 16'h0000, 16'h0000);   // R12
        drive(K_CMP,  8'h35, 8'h35, 16'h0, 16'h0);          // R1 equal
        drive(K_CMP,  8'h10, 8'h21, 16'h0, 16'h0);          // R1 borrow both
        drive(K_CMP,  8'h80, 8'h01, 16'h0, 16'h0);          // R1 half borrow only
        drive(K_SETC, 8'h00, 8'h00, 16'h0, 16'h0);          // R9
        drive(K_INC,  8'h00, 8'hFF, 16'h0, 16'h0);          // R2 wrap, CY kept
        drive(K_INC,  8'h00, 8'h0F, 16'h0, 16'h0);          // R2 half carry
        drive(K_DEC,  8'h00, 8'h00, 16'h0, 16'h0);          // R2 wrap down
        drive(K_DEC,  8'h00, 8'h01, 16'h0, 16'h0);          // R2 zero
        drive(K_CLRC, 8'h00, 8'h00, 16'h0, 16'h0);          // R9
        drive(K_NOTC, 8'h00, 8'h00, 16'h0, 16'h0);          // R9
        drive(K_NOTC, 8'h00, 8'h00, 16'h0, 16'h0);          // R9
        drive(K_ADDW, 8'h00, 8'h00, 16'hFFFF, 16'h0001);    // R3 all carry, zero
        drive(K_ADDW, 8'h00, 8'h00, 16'h1234, 16'h0F0F);    // R3
        drive(K_SUBW, 8'h00, 8'h00, 16'h0001, 16'h0002);    // R4 borrow
        drive(K_CMPW, 8'h00, 8'h00, 16'h1234, 16'h1234);    // R4 no writeback
        drive(K_INCW, 8'h00, 8'h00, 16'hFFFF, 16'h0000);    // R5 flags held
        drive(K_DECW, 8'h00, 8'h00, 16'h0000, 16'h0000);    // R5
        drive(K_ROR,  8'h81, 8'h00, 16'h0, 16'h0);          // R6
        drive(K_ROL,  8'h81, 8'h00, 16'h0, 16'h0);          // R6
        drive(K_CLRC, 8'h00, 8'h00, 16'h0, 16'h0);
        drive(K_RORC, 8'h01, 8'h00, 16'h0, 16'h0);          // R7 old CY 0
        drive(K_ROLC, 8'h80, 8'h00, 16'h0, 16'h0);          // R7 old CY 1
        drive(K_ROLC, 8'h00, 8'h00, 16'h0, 16'h0);          // R7
        drive(K_RORC, 8'hFE, 8'h00, 16'h0, 16'h0);          // R7, R8
        drive(K_SETC, 8'h00, 8'h00, 16'h0, 16'h0);
        do_reset();                                          // R11 mid-run
        for (int i = 0; i < 400; i++)
            drive(4'($urandom), 8'($urandom), 8'($urandom), 16'($urandom), 16'($urandom));
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule